// File: doc/BRIEF.md
# Strobe-Handshake Processor Bus Slave

This block connects an external processor to a small internal register file and a 32-bit-wide word memory. The processor bus is asynchronous: chip enable, an active-low data strobe, a read/write select, an address bus and a data bus. Completion is signalled back with a data-acknowledge line. The block runs on its own system clock. It brings chip enable and strobe through a two-flop synchronizer and detects the strobe edges. On a detected falling strobe edge it latches the address, the data and the direction, and then decodes them.

The acknowledge timing depends on the kind of access. A write is acknowledged as soon as the strobe fall is seen. A register read is acknowledged one clock later. A memory read is acknowledged only after the word has come out of the memory and been captured. The acknowledge is removed once the strobe's rising edge is seen.

When the bus is 16 bits wide, each 32-bit memory word is moved in two halves. On writes, the low half is held and the whole word is committed with the high half. On reads, the full word is captured on the low-half access, so the high-half access returns quickly.

Top module: `strobe_bus_slave`

## Requirements
- R1: After reset `ack` is 0, `rdata` is 0 and every internal register reads back as 0.
- R2: For a write, `ack` rises on the third rising clock edge after the falling strobe is first sampled. This is the edge at which the synchronized falling edge is detected.
- R3: `ack` falls on the third rising clock edge after the rising strobe is first sampled. A following access is then accepted normally.
- R4: A register read (`addr[5]`=0, register index `addr[2:0]`) raises `ack` one clock later than a write, on the fourth edge. It returns `{16'h0, register}` on `rdata`.
- R5: Register accesses behave the same in both bus modes. Only `wdata[15:0]` is stored and `wdata[31:16]` is ignored.
- R6: In 16-bit mode (`wide_mode`=0), a memory write (`addr[5]`=1, word index `addr[4:1]`) with half-select `addr[0]`=0 only holds `wdata[15:0]` and leaves memory unchanged. A write with `addr[0]`=1 commits the word `{wdata[15:0], held low half}`.
- R7: In 16-bit mode, a memory read with `addr[0]`=0 captures the whole 32-bit word and returns `{16'h0, word[15:0]}` with `ack` on the fifth edge. A read with `addr[0]`=1 returns `{16'h0, captured word[31:16]}` with `ack` on the third edge.
- R8: In 32-bit mode (`wide_mode`=1), a memory write commits all of `wdata` in one access, acknowledged on the third edge. A memory read returns the full word, acknowledged on the fifth edge.
- R9: A falling strobe seen while `cs_n` is high is ignored: no `ack` is raised and nothing is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wide_mode | input | 1 | 1 = 32-bit bus mode, 0 = 16-bit bus mode |
| cs_n | input | 1 | Chip enable, active low, asynchronous |
| stb_n | input | 1 | Data strobe, active low, asynchronous |
| rd_wr | input | 1 | 1 = read, 0 = write |
| addr | input | 6 | Bus address; bit 5 selects memory |
| wdata | input | 32 | Write data from the processor |
| rdata | output | 32 | Read data to the processor |
| ack | output | 1 | Registered data acknowledge, active high |

## Verification
Each result has a fixed due cycle, counted in rising edges from the first edge that samples the falling strobe:
- a write, or a high-half memory read in 16-bit mode, acknowledges on edge 3;
- a register read acknowledges on edge 4;
- any other memory read acknowledges on edge 5;
- the acknowledge drops on edge 3 after the strobe rises.

The driver timestamps the strobe change with an edge counter and queues the due cycle and the expected data. The monitor samples on the falling clock edge and compares the counter value at the moment `ack` rises. A late or early acknowledge therefore counts as a mismatch, and so does data that is wrong at that moment.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_COMMIT,
      ST_REG_RD,
      ST_MEM_RD,
      ST_MEM_CAP
   } sbs_state_e;
endpackage

// File: rtl/sbs_sync.sv
// Multi-stage synchronizer with edge detection on the synchronized level.
module sbs_sync #(
   parameter int               WIDTH    = 2,
   parameter int               STAGES   = 2,
   parameter logic [WIDTH-1:0] IDLE_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] level,
   output logic [WIDTH-1:0] fall,
   output logic [WIDTH-1:0] rise
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sbs_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] pipe;
   logic [WIDTH-1:0]             last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pipe <= {STAGES{IDLE_VAL}};
         last <= IDLE_VAL;
      end else begin
         pipe <= {pipe[STAGES-2:0], din};
         last <= pipe[STAGES-1];
      end
   end

   assign level = pipe[STAGES-1];
   assign fall  = last & ~level;
   assign rise  = ~last & level;
endmodule

// File: rtl/sbs_regs.sv
// Register file: one flop bank per entry, combinational read.
module sbs_regs #(
   parameter int N  = 8,
   parameter int DW = 16,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [IW-1:0] widx,
   input  logic [DW-1:0] wdata,
   input  logic [IW-1:0] ridx,
   output logic [DW-1:0] rdata
);
   logic [N-1:0][DW-1:0] bank;

   generate
      for (genvar g = 0; g < N; g++) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               bank[g] <= '0;
            else if (we && widx == IW'(g))
               bank[g] <= wdata;
         end
      end
   endgenerate

   assign rdata = bank[ridx];
endmodule

// File: rtl/sbs_mem.sv
// Synchronous word memory with a registered read port.
module sbs_mem #(
   parameter int DEPTH = 16,
   parameter int DW    = 32,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic          re,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   logic [DW-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[waddr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  rdata <= '0;
      else if (re) rdata <= cells[raddr];
   end
endmodule

// File: rtl/strobe_bus_slave.sv
module strobe_bus_slave
   import sbs_pkg::*;
#(
   parameter int AW        = 6,
   parameter int DW        = 32,
   parameter int REG_N     = 8,
   parameter int MEM_DEPTH = 16,
   parameter int SYNC_STG  = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wide_mode,
   input  logic          cs_n,
   input  logic          stb_n,
   input  logic          rd_wr,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata,
   output logic          ack
);
   localparam int HW  = DW / 2;
   localparam int RIW = (REG_N > 1) ? $clog2(REG_N) : 1;
   localparam int MIW = (MEM_DEPTH > 1) ? $clog2(MEM_DEPTH) : 1;

   generate
      if (DW % 2 != 0) begin : g_bad_dw
         $error("strobe_bus_slave: DW must be even");
      end
      if (RIW > AW - 1) begin : g_bad_reg
         $error("strobe_bus_slave: register index does not fit the address");
      end
      if (MIW + 1 > AW - 1) begin : g_bad_mem
         $error("strobe_bus_slave: memory index does not fit the address");
      end
   endgenerate

   // ---- synchronizer: bit 1 = chip enable, bit 0 = strobe ----
   logic [1:0] s_level, s_fall, s_rise;

   sbs_sync #(.WIDTH(2), .STAGES(SYNC_STG), .IDLE_VAL(2'b11)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   ({cs_n, stb_n}),
      .level (s_level),
      .fall  (s_fall),
      .rise  (s_rise)
   );

   logic stb_fall, stb_rise, cs_on;
   assign stb_fall = s_fall[0];
   assign stb_rise = s_rise[0];
   assign cs_on    = ~s_level[1];

   sbs_state_e    state;
   logic [AW-1:0] a_q;
   logic [DW-1:0] d_q;
   logic          m32_q;
   logic [HW-1:0] hold_q;
   logic [DW-1:0] cap_q;

   logic start, in_mem, in_hi_half, q_mem;
   assign start      = stb_fall & cs_on & (state == ST_IDLE);
   assign in_mem     = addr[AW-1];
   assign in_hi_half = in_mem & ~wide_mode & addr[0];
   assign q_mem      = a_q[AW-1];

   // ---- register file ----
   logic          reg_we;
   logic [HW-1:0] reg_rd;
   assign reg_we = (state == ST_COMMIT) & ~q_mem;

   sbs_regs #(.N(REG_N), .DW(HW)) i_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (reg_we),
      .widx  (a_q[RIW-1:0]),
      .wdata (d_q[HW-1:0]),
      .ridx  (a_q[RIW-1:0]),
      .rdata (reg_rd)
   );

   // ---- word memory ----
   logic          mem_we, mem_re;
   logic [DW-1:0] mem_wd, mem_rd;
   assign mem_we = (state == ST_COMMIT) & q_mem & (m32_q | a_q[0]);
   assign mem_re = (state == ST_MEM_RD);
   assign mem_wd = m32_q ? d_q : {d_q[HW-1:0], hold_q};

   sbs_mem #(.DEPTH(MEM_DEPTH), .DW(DW)) i_mem (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (mem_we),
      .waddr (a_q[MIW:1]),
      .wdata (mem_wd),
      .re    (mem_re),
      .raddr (a_q[MIW:1]),
      .rdata (mem_rd)
   );

   // ---- access sequencer ----
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         ack    <= 1'b0;
         rdata  <= '0;
         a_q    <= '0;
         d_q    <= '0;
         m32_q  <= 1'b0;
         hold_q <= '0;
         cap_q  <= '0;
      end else begin
         if (stb_rise) ack <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start) begin
                  a_q   <= addr;
                  d_q   <= wdata;
                  m32_q <= wide_mode;
                  if (!rd_wr) begin
                     ack   <= 1'b1;
                     state <= ST_COMMIT;
                  end else if (in_hi_half) begin
                     rdata <= {{HW{1'b0}}, cap_q[DW-1:HW]};
                     ack   <= 1'b1;
                  end else if (in_mem) begin
                     state <= ST_MEM_RD;
                  end else begin
                     state <= ST_REG_RD;
                  end
               end
            end
            ST_COMMIT: begin
               if (q_mem && !m32_q && !a_q[0]) hold_q <= d_q[HW-1:0];
               state <= ST_IDLE;
            end
            ST_REG_RD: begin
               rdata <= {{HW{1'b0}}, reg_rd};
               ack   <= 1'b1;
               state <= ST_IDLE;
            end
            ST_MEM_RD: state <= ST_MEM_CAP;
            ST_MEM_CAP: begin
               cap_q <= mem_rd;
               rdata <= m32_q ? mem_rd : {{HW{1'b0}}, mem_rd[HW-1:0]};
               ack   <= 1'b1;
               state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // ---- assertions ----
   a_r2_write_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !rd_wr) |=> ack);

   a_r3_ack_release: assert property (@(posedge clk) disable iff (!rst_n)
      stb_rise |=> !ack);

   a_r4_read_waits: assert property (@(posedge clk) disable iff (!rst_n)
      (start && rd_wr && !in_hi_half) |=> !ack);

   a_r6_half0_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !rd_wr && in_mem && !wide_mode && !addr[0]) |=> !mem_we);

   a_r7_half1_fast: assert property (@(posedge clk) disable iff (!rst_n)
      (start && rd_wr && in_hi_half) |=> ack);

   a_r9_ignore_no_cs: assert property (@(posedge clk) disable iff (!rst_n)
      (stb_fall && !cs_on && state == ST_IDLE && !ack) |=> (!ack && state == ST_IDLE));
endmodule

// File: tb/test_strobe_bus_slave.sv
`timescale 1ns/1ps
module test_strobe_bus_slave;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wide_mode = 1'b0;
   logic        cs_n = 1'b1;
   logic        stb_n = 1'b1;
   logic        rd_wr = 1'b1;
   logic [5:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        ack;

   strobe_bus_slave i_strobe_bus_slave (
      .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .cs_n(cs_n),
      .stb_n(stb_n), .rd_wr(rd_wr), .addr(addr), .wdata(wdata),
      .rdata(rdata), .ack(ack)
   );

   always #2 clk = ~clk;   // 250 MHz

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int  n_cmp = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;

   typedef struct {
      string       tag;
      int          due;
      bit          rd;
      logic [31:0] exp;
   } item_t;
   item_t sb[$];

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [5:0] maddr(input int w, input bit half);
      return {1'b1, w[3:0], half};
   endfunction

   function automatic logic [5:0] raddr(input int r);
      return {3'b000, r[2:0]};
   endfunction

   // monitor: compare ack rise cycle and read data against queue
   logic ack_prev = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (ack && !ack_prev) begin
            if (sb.size() == 0) begin
               chk(1'b0, "R9 unexpected ack", 32'(ack), 32'h0);
            end else begin
               item_t it;
               it = sb.pop_front();
               chk(cyc == it.due, {it.tag, " ack cycle"}, 32'(cyc), 32'(it.due));
               if (it.rd) chk(rdata == it.exp, {it.tag, " rdata"}, rdata, it.exp);
            end
         end
         ack_prev <= ack;
      end
   end

   // driver: one complete handshake
   task automatic access(input bit rd, input logic [5:0] a, input logic [31:0] d,
                         input int lat, input logic [31:0] exp, input string tag);
      int t;
      @(negedge clk);
      cs_n = 1'b0; rd_wr = rd; addr = a; wdata = d;
      @(negedge clk);
      stb_n = 1'b0;
      sb.push_back('{tag: tag, due: cyc + lat, rd: rd, exp: exp});
      do @(negedge clk); while (!ack);
      stb_n = 1'b1;
      t = cyc;
      do @(negedge clk); while (ack);
      chk(cyc == t + 3, "R3 ack release cycle", 32'(cyc), 32'(t + 3));
      cs_n = 1'b1; rd_wr = 1'b1;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(ack == 1'b0, "R1 reset ack", 32'(ack), 32'h0);
      chk(rdata == 32'h0, "R1 reset rdata", rdata, 32'h0);

      // 16-bit mode registers
      wide_mode = 1'b0;
      access(1'b1, raddr(5), '0, 4, 32'h0, "R1 register reset value");
      access(1'b0, raddr(2), 32'hFFFF_1234, 3, '0, "R2 register write");
      access(1'b1, raddr(2), '0, 4, 32'h0000_1234, "R4 register read");

      // 32-bit mode registers: high word ignored
      wide_mode = 1'b1;
      access(1'b0, raddr(3), 32'hABCD_5678, 3, '0, "R5 wide register write");
      access(1'b1, raddr(3), '0, 4, 32'h0000_5678, "R5 wide register read");
      wide_mode = 1'b0;
      access(1'b1, raddr(3), '0, 4, 32'h0000_5678, "R5 narrow read of wide write");

      // 32-bit memory
      wide_mode = 1'b1;
      access(1'b0, maddr(1, 0), 32'h1111_2222, 3, '0, "R8 wide mem write");
      access(1'b1, maddr(1, 0), '0, 5, 32'h1111_2222, "R8 wide mem read");
      access(1'b0, maddr(3, 1), 32'hDEAD_BEEF, 3, '0, "R8 wide mem write half bit set");
      access(1'b1, maddr(3, 0), '0, 5, 32'hDEAD_BEEF, "R8 wide mem read word3");

      // 16-bit memory write in halves
      wide_mode = 1'b0;
      access(1'b0, maddr(1, 0), 32'h7777_BEEF, 3, '0, "R6 half0 write");
      wide_mode = 1'b1;
      access(1'b1, maddr(1, 0), '0, 5, 32'h1111_2222, "R6 memory unchanged after half0");
      wide_mode = 1'b0;
      access(1'b0, maddr(1, 1), 32'h5555_CAFE, 3, '0, "R6 half1 commit write");
      wide_mode = 1'b1;
      access(1'b1, maddr(1, 0), '0, 5, 32'hCAFE_BEEF, "R6 committed word");

      // 16-bit memory reads in halves
      wide_mode = 1'b0;
      access(1'b1, maddr(1, 0), '0, 5, 32'h0000_BEEF, "R7 half0 read");
      access(1'b1, maddr(1, 1), '0, 3, 32'h0000_CAFE, "R7 half1 read");
      access(1'b1, maddr(3, 0), '0, 5, 32'h0000_BEEF, "R7 half0 read word3");
      access(1'b1, maddr(3, 1), '0, 3, 32'h0000_DEAD, "R7 half1 read word3");

      // strobe without chip enable is ignored
      begin
         bit seen;
         seen = 1'b0;
         @(negedge clk);
         cs_n = 1'b1; rd_wr = 1'b0; addr = raddr(2); wdata = 32'h0000_9999;
         @(negedge clk);
         stb_n = 1'b0;
         for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (ack) seen = 1'b1;
         end
         chk(!seen, "R9 no ack without chip enable", 32'(seen), 32'h0);
         stb_n = 1'b1; rd_wr = 1'b1;
         repeat (4) @(negedge clk);
      end
      access(1'b1, raddr(2), '0, 4, 32'h0000_1234, "R9 register untouched");

      repeat (4) @(negedge clk);
      chk(sb.size() == 0, "R2 all acks seen", 32'(sb.size()), 32'h0);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule